// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of a free-running timer when a chosen event occurs on an external input pin. The pin is asynchronous to the system clock. It passes through a two-flop synchronizer and then an edge detector. An optional event prescaler follows, and the timer value seen in the cycle of the event is latched into a capture register. Each capture sets a sticky interrupt flag, which software clears through a dedicated input.

Software selects the event with a 4-bit mode written through a one-cycle write strobe:

| Mode | Event |
|---|---|
| `0000` | off |
| `0100` | each falling edge |
| `0101` | each rising edge |
| `0110` | every 4th rising edge |
| `0111` | every 16th rising edge |

The unit treats every other code as a non-capture mode.

The prescaler behaves as follows:
- It survives a switch from one capture mode to another, so a switch can bring the next capture forward.
- Any write that changes the mode sets the flag, as a spurious interrupt.
- The timer must advance more slowly than the system clock for the captured values to be meaningful.

Top module: `edge_capture`

## Requirements
- R1: After reset, `cap_val` is 0, `cap_flag` is 0 and the mode is off (`0000`), so pin edges cause no capture.
- R2: In mode `0100`, each falling edge of `pin_in` captures `tmr_val` into `cap_val`, and rising edges capture nothing.
- R3: In mode `0101`, each rising edge of `pin_in` captures `tmr_val`, and falling edges capture nothing.
- R4: In mode `0110`, a capture occurs on every 4th rising edge, counted from a cleared prescaler. The prescaler then wraps to zero.
- R5: In mode `0111`, a capture occurs on every 16th rising edge, counted from a cleared prescaler. The prescaler then wraps to zero.
- R6: `cap_val` takes the `tmr_val` present just before the third rising clock edge after `pin_in` changes, and shows it after that edge.
- R7: A capture sets `cap_flag`. The flag stays set until `flag_clr` is high at a clock edge, and only then does it fall.
- R8: A second capture overwrites `cap_val` even if the flag was never cleared.
- R9: While the mode is off or not a capture mode, no capture occurs and the prescaler is held cleared. On re-entering a divided mode, the count starts from zero.
- R10: Switching directly between capture modes keeps the prescaler count. After 6 rising edges in mode `0111`, a switch to `0110` captures on the 2nd following rising edge, because the 4-edge mode fires when the low two count bits are `11`.
- R11: A mode write whose value differs from the current mode sets `cap_flag` without changing `cap_val`. A write of the same value leaves the flag alone.
- R12: If `flag_clr` and a capture fall at the same clock edge, `cap_flag` ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous capture input pin |
| tmr_val | input | 16 | Current timer value |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 4 | Mode value to write |
| cap_val | output | 16 | Capture register |
| cap_flag | output | 1 | Sticky capture interrupt flag |
| flag_clr | input | 1 | Clears the flag at the clock edge when high |

## Verification
A capture and a software clear of the flag can land on the same clock edge. The bench provokes this by raising `flag_clr` in exactly the cycle before the third clock edge after a pin rise, and it requires the flag to be set afterwards. A control case raises the clear alone and expects the flag to drop. A mode write and a pin edge can also share a cycle. The bench keeps them apart so that each spurious flag can be told from a real capture by reading `cap_val`.

// File: rtl/edge_capture.sv
module edge_capture #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [TW-1:0] tmr_val,
  input  logic          mode_we,
  input  logic [3:0]    mode_wdata,
  output logic [TW-1:0] cap_val,
  output logic          cap_flag,
  input  logic          flag_clr
);

  logic [1:0]    sync_q;
  logic          pin_d;
  logic [3:0]    mode_q;
  logic [3:0]    pre_cnt;
  logic [TW-1:0] cap_q;
  logic          flag_q;
  logic          rise, fall, is_cap, cap_evt, mode_chg;

  assign rise     = sync_q[1] & ~pin_d;
  assign fall     = ~sync_q[1] & pin_d;
  assign is_cap   = (mode_q[3:2] == 2'b01);
  assign mode_chg = mode_we && (mode_wdata != mode_q);

  always_comb begin
    case (mode_q)
      4'b0100: cap_evt = fall;
      4'b0101: cap_evt = rise;
      4'b0110: cap_evt = rise && (pre_cnt[1:0] == 2'b11);
      4'b0111: cap_evt = rise && (pre_cnt == 4'hF);
      default: cap_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      pin_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_in};
      pin_d  <= sync_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= 4'b0000;
    else if (mode_we)
      mode_q <= mode_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !is_cap)
      pre_cnt <= '0;
    else if (rise && mode_q[1])
      pre_cnt <= cap_evt ? 4'd0 : pre_cnt + 4'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_evt)
        cap_q <= tmr_val;
      if (cap_evt || mode_chg)
        flag_q <= 1'b1;
      else if (flag_clr)
        flag_q <= 1'b0;
    end
  end

  assign cap_val  = cap_q;
  assign cap_flag = flag_q;

  // R8
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(tmr_val)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cap |=> $stable(cap_q));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  // R7
  flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(flag_clr));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag_q);

endmodule

// File: tb/edge_capture_tb_top.sv
module edge_capture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic [15:0] tmr_val = '0;
  logic        mode_we = 1'b0;
  logic [3:0]  mode_wdata = '0;
  logic [15:0] cap_val;
  logic        cap_flag;
  logic        flag_clr = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .tmr_val(tmr_val),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .cap_val(cap_val),
    .cap_flag(cap_flag), .flag_clr(flag_clr)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_wdata = m; mode_we = 1'b1;
    tick();
    mode_we = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
  endtask

  task automatic edge_to(input logic lvl, input logic [15:0] t);
    tmr_val = t;
    pin_in = lvl;
    tick(4);
  endtask

  task automatic rise_pulse(input logic [15:0] t);
    edge_to(1'b1, t);
    edge_to(1'b0, t);
  endtask

  task automatic t_reset();
    chk("R1 cap_val", cap_val, 16'h0000);
    chk("R1 cap_flag", {15'd0, cap_flag}, 16'h0000);
    rise_pulse(16'h1111);
    chk("R1 off no capture", cap_val, 16'h0000);
    chk("R1 off no flag", {15'd0, cap_flag}, 16'h0000);
  endtask

  task automatic t_mode_change_flag();
    set_mode(4'b0101);
    chk("R11 change sets flag", {15'd0, cap_flag}, 16'h0001);
    chk("R11 change keeps cap_val", cap_val, 16'h0000);
    clear_flag();
    chk("R7 clear drops flag", {15'd0, cap_flag}, 16'h0000);
    set_mode(4'b0101);
    chk("R11 same value no flag", {15'd0, cap_flag}, 16'h0000);
  endtask

  task automatic t_rising();
    edge_to(1'b1, 16'h2222);
    chk("R3 rise captures", cap_val, 16'h2222);
    chk("R7 capture sets flag", {15'd0, cap_flag}, 16'h0001);
    tick(5);
    chk("R7 flag sticky", {15'd0, cap_flag}, 16'h0001);
    edge_to(1'b0, 16'h3333);
    chk("R3 fall ignored", cap_val, 16'h2222);
    edge_to(1'b1, 16'h4444);
    chk("R8 overwrite without clear", cap_val, 16'h4444);
    edge_to(1'b0, 16'h0);
    clear_flag();
  endtask

  task automatic t_falling();
    set_mode(4'b0100);
    clear_flag();
    edge_to(1'b1, 16'h5555);
    chk("R2 rise ignored", cap_val, 16'h4444);
    chk("R2 no flag on rise", {15'd0, cap_flag}, 16'h0000);
    edge_to(1'b0, 16'h6666);
    chk("R2 fall captures", cap_val, 16'h6666);
    clear_flag();
  endtask

  task automatic t_latency();
    set_mode(4'b0101);
    clear_flag();
    tmr_val = 16'hA000; pin_in = 1'b1;
    tick(); tmr_val = 16'hA001;
    tick(); tmr_val = 16'hA002;
    chk("R6 not yet captured", cap_val, 16'h6666);
    tick(); tmr_val = 16'hA003;
    chk("R6 value at third edge", cap_val, 16'hA002);
    tick();
    chk("R6 no later reload", cap_val, 16'hA002);
    edge_to(1'b0, 16'h0);
    clear_flag();
  endtask

  task automatic t_div4_and_off();
    set_mode(4'b0000);
    set_mode(4'b0110);
    clear_flag();
    for (int i = 1; i <= 3; i++) rise_pulse(16'h0400 + 16'(i));
    chk("R4 no capture before 4th", cap_val, 16'hA002);
    rise_pulse(16'h0404);
    chk("R4 capture on 4th", cap_val, 16'h0404);
    for (int i = 1; i <= 3; i++) rise_pulse(16'h0410 + 16'(i));
    chk("R4 wrap no early capture", cap_val, 16'h0404);
    rise_pulse(16'h0414);
    chk("R4 capture on 8th", cap_val, 16'h0414);
    rise_pulse(16'h0421); rise_pulse(16'h0422);
    set_mode(4'b0000);
    rise_pulse(16'h0430);
    chk("R9 off no capture", cap_val, 16'h0414);
    set_mode(4'b1100);
    rise_pulse(16'h0431);
    chk("R9 non-capture code no capture", cap_val, 16'h0414);
    set_mode(4'b0110);
    clear_flag();
    for (int i = 1; i <= 3; i++) rise_pulse(16'h0440 + 16'(i));
    chk("R9 prescaler cleared by off", cap_val, 16'h0414);
    rise_pulse(16'h0444);
    chk("R9 capture on 4th after re-entry", cap_val, 16'h0444);
    clear_flag();
  endtask

  task automatic t_div16();
    set_mode(4'b0000);
    set_mode(4'b0111);
    clear_flag();
    for (int i = 1; i <= 15; i++) rise_pulse(16'h1600 + 16'(i));
    chk("R5 no capture before 16th", cap_val, 16'h0444);
    chk("R5 no flag before 16th", {15'd0, cap_flag}, 16'h0000);
    rise_pulse(16'h1616);
    chk("R5 capture on 16th", cap_val, 16'h1616);
    clear_flag();
  endtask

  task automatic t_switch_keeps();
    set_mode(4'b0000);
    set_mode(4'b0111);
    for (int i = 1; i <= 6; i++) rise_pulse(16'h7700 + 16'(i));
    set_mode(4'b0110);
    clear_flag();
    rise_pulse(16'h7711);
    chk("R10 no capture on 1st after switch", cap_val, 16'h1616);
    rise_pulse(16'h7712);
    chk("R10 early capture on 2nd after switch", cap_val, 16'h7712);
    clear_flag();
  endtask

  task automatic t_clear_vs_capture();
    set_mode(4'b0101);
    chk("R12 flag set before", {15'd0, cap_flag}, 16'h0001);
    tmr_val = 16'hC0DE; pin_in = 1'b1;
    tick(2);
    flag_clr = 1'b1;
    tick();
    flag_clr = 1'b0;
    chk("R12 capture wins over clear", {15'd0, cap_flag}, 16'h0001);
    chk("R12 value captured", cap_val, 16'hC0DE);
    clear_flag();
    chk("R7 lone clear drops flag", {15'd0, cap_flag}, 16'h0000);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_mode_change_flag();
    t_rising();
    t_falling();
    t_latency();
    t_div4_and_off();
    t_div16();
    t_switch_keeps();
    t_clear_vs_capture();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule